// File: doc/BRIEF.md
# Two-Output Level Interrupt Aggregator

This block gathers a vector of level-sensitive interrupt requests from peripherals and turns them into two processor interrupt signals: a normal request and a fast request. Every input line is qualified by its own bit in a software-visible enable mask. One line, chosen by a parameter (line 8 by default), feeds only the fast request. All remaining lines feed only the normal request.

A small register port gives access to two words. The enable word can be read and written, and a write replaces the whole mask. The pending word is read-only and shows the input lines ANDed with the mask. Nothing latches: a request is pending only while its input line is high.

Both processor outputs are registered. They are recomputed on every clock from the present inputs and the present mask. Read data comes back on the cycle after the request.

Top module: `intc_top`

## Requirements
- R1: While `rst` is high at a clock edge, the enable mask loads 0xFFFEF7FF, so lines 11 and 16 start disabled and all others enabled. In the same cycle `irq_out`, `fiq_out` and `bus_rdata` are cleared to 0.
- R2: A write request (`bus_req`=1, `bus_we`=1) to byte offset 0x48 replaces all 32 mask bits with `bus_wdata`. A read request (`bus_we`=0) to 0x48 returns the mask on `bus_rdata` one cycle later.
- R3: A read request to byte offset 0x44 returns `irq_lines & mask` one cycle later.
- R4: A write to offset 0x44 leaves the mask unchanged.
- R5: A read from any offset other than 0x44 or 0x48, including unaligned ones such as 0x45, returns 0. A write to such an offset leaves the mask unchanged.
- R6: `irq_out` is 1 one cycle after any bit other than bit 8 of `irq_lines & mask` is 1, and 0 otherwise.
- R7: `fiq_out` is 1 one cycle after bit 8 of `irq_lines & mask` is 1, and 0 otherwise. Line 8 never drives `irq_out`.
- R8: Requests are not latched. When an enabled line falls, its output drops one cycle later, provided no other enabled line on the same output is high.
- R9: A mask write takes effect on the outputs one cycle after the edge that stores it. In the cycle right after that edge, the outputs still reflect the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read request, otherwise 0 |
| irq_lines | input | 32 | Level-sensitive interrupt requests, synchronous to clk |
| irq_out | output | 1 | Normal interrupt to the processor |
| fiq_out | output | 1 | Fast interrupt to the processor |

## Verification
Every result here is due exactly one clock edge after its cause:
- The outputs follow a change on `irq_lines` one edge later.
- A read returns its data one edge after the request.
- A mask write is stored at one edge and reaches the outputs at the next.

The bench drives inputs on the falling edge and samples on the following falling edge, so exactly one rising edge lies between stimulus and check. For the mask-write case it samples twice: once to confirm the outputs still show the old mask, and once more to confirm the new one. The sweeps cover every line alone under the reset mask, then pseudo-random line and mask patterns, with the expected values worked out arithmetically in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Register selection after offset decode
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2
    } reg_sel_e;

    // Pair of processor-facing interrupt signals
    typedef struct packed {
        logic irq;
        logic fiq;
    } cpu_int_t;

    localparam int unsigned OFS_W = 16;

    // Exact-match decode of a byte offset; anything else selects nothing
    function automatic reg_sel_e decode_offset(
        input logic [OFS_W-1:0] ofs,
        input logic [OFS_W-1:0] status_ofs,
        input logic [OFS_W-1:0] enable_ofs
    );
        if (ofs == status_ofs)      return SEL_STATUS;
        else if (ofs == enable_ofs) return SEL_ENABLE;
        else                        return SEL_NONE;
    endfunction

endpackage

// File: rtl/intc_route.sv
module intc_route #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned FAST_LINE = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines,
    input  logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] masked,
    output intc_pkg::cpu_int_t   cpu_int
);
    logic [NUM_LINES-1:0] to_fast;
    intc_pkg::cpu_int_t   cpu_int_d;

    // Per-line steering: one fixed line goes to the fast output
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_steer
        assign to_fast[g] = (g == FAST_LINE);
    end

    assign masked = lines & mask;

    always_comb begin
        cpu_int_d.irq = |(masked & ~to_fast);
        cpu_int_d.fiq = |(masked &  to_fast);
    end

    always_ff @(posedge clk) begin
        if (rst) cpu_int <= '0;
        else     cpu_int <= cpu_int_d;
    end
endmodule

// File: rtl/intc_regs.sv
module intc_regs #(
    parameter int unsigned          NUM_LINES  = 32,
    parameter int unsigned          ADDR_W     = 8,
    parameter int unsigned          STATUS_OFS = 'h44,
    parameter int unsigned          ENABLE_OFS = 'h48,
    parameter logic [NUM_LINES-1:0] ENABLE_RST = 32'hFFFE_F7FF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LINES-1:0] wdata,
    input  logic [NUM_LINES-1:0] pending,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] rdata
);
    import intc_pkg::*;

    localparam logic [OFS_W-1:0] ST_OFS = OFS_W'(STATUS_OFS);
    localparam logic [OFS_W-1:0] EN_OFS = OFS_W'(ENABLE_OFS);

    reg_sel_e             sel;
    logic [NUM_LINES-1:0] rd_mux;

    assign sel = decode_offset(OFS_W'(addr), ST_OFS, EN_OFS);

    always_comb begin
        case (sel)
            SEL_STATUS: rd_mux = pending;
            SEL_ENABLE: rd_mux = mask;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= ENABLE_RST;
            rdata <= '0;
        end else begin
            if (req && we && sel == SEL_ENABLE) mask <= wdata;
            rdata <= (req && !we) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top #(
    parameter int unsigned          NUM_LINES  = 32,
    parameter int unsigned          ADDR_W     = 8,
    parameter int unsigned          FAST_LINE  = 8,
    parameter int unsigned          STATUS_OFS = 'h44,
    parameter int unsigned          ENABLE_OFS = 'h48,
    parameter logic [NUM_LINES-1:0] ENABLE_RST = 32'hFFFE_F7FF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_out,
    output logic                 fiq_out
);
    logic [NUM_LINES-1:0] mask;
    logic [NUM_LINES-1:0] masked;
    intc_pkg::cpu_int_t   cpu_int;

    intc_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .STATUS_OFS(STATUS_OFS),
        .ENABLE_OFS(ENABLE_OFS),
        .ENABLE_RST(ENABLE_RST)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (bus_req),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .pending(masked),
        .mask   (mask),
        .rdata  (bus_rdata)
    );

    intc_route #(
        .NUM_LINES(NUM_LINES),
        .FAST_LINE(FAST_LINE)
    ) u_route (
        .clk    (clk),
        .rst    (rst),
        .lines  (irq_lines),
        .mask   (mask),
        .masked (masked),
        .cpu_int(cpu_int)
    );

    assign irq_out = cpu_int.irq;
    assign fiq_out = cpu_int.fiq;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int unsigned NUM_LINES  = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned FAST_LINE  = 8,
    parameter int unsigned ENABLE_OFS = 'h48,
    parameter int unsigned STATUS_OFS = 'h44
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_LINES-1:0] bus_wdata,
    input logic [NUM_LINES-1:0] bus_rdata,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic [NUM_LINES-1:0] mask,
    input logic                 irq_out,
    input logic                 fiq_out
);
    localparam logic [NUM_LINES-1:0] FAST_BIT = NUM_LINES'(1) << FAST_LINE;

    logic en_wr, st_rd;
    assign en_wr = bus_req && bus_we && (bus_addr == ADDR_W'(ENABLE_OFS));
    assign st_rd = bus_req && !bus_we && (bus_addr == ADDR_W'(STATUS_OFS));

    a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (mask == $past(bus_wdata)));

    a_r5_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(mask));

    a_r3_status_read: assert property (@(posedge clk) disable iff (rst)
        st_rd |=> (bus_rdata == $past(irq_lines & mask)));

    a_r6_irq_out: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|(irq_lines & mask & ~FAST_BIT))));

    a_r7_fiq_out: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fiq_out == $past(|(irq_lines & mask & FAST_BIT))));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> (bus_rdata == '0));
endmodule

bind intc_top intc_checker #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .FAST_LINE (FAST_LINE),
    .ENABLE_OFS(ENABLE_OFS),
    .STATUS_OFS(STATUS_OFS)
) u_intc_checker (
    .clk      (clk),
    .rst      (rst),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_lines(irq_lines),
    .mask     (mask),
    .irq_out  (irq_out),
    .fiq_out  (fiq_out)
);

// File: tb/test_intc_top.sv
module test_intc_top;
    localparam logic [31:0] RST_MASK = 32'hFFFE_F7FF;
    localparam logic [31:0] FAST     = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_lines = '0;
    logic        irq_out, fiq_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic [31:0] model_mask;
    logic [31:0] seed = 32'h1234_5678;
    logic [31:0] rd;

    always #5 clk = ~clk;

    intc_top i_intc_top (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    // Apply lines, then check both outputs one edge later
    task automatic drive_check(input string req, input logic [31:0] ln);
        logic [31:0] p;
        @(negedge clk);
        irq_lines = ln;
        @(negedge clk);
        p = ln & model_mask;
        chk({req, " irq"}, {31'b0, irq_out}, {31'b0, |(p & ~FAST)});
        chk({req, " fiq"}, {31'b0, fiq_out}, {31'b0, |(p & FAST)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_mask = RST_MASK;
        @(negedge clk);
        // R1: reset state
        chk("R1 irq", {31'b0, irq_out}, 32'd0);
        chk("R1 fiq", {31'b0, fiq_out}, 32'd0);
        chk("R1 rdata", bus_rdata, 32'd0);
        bus_read(8'h48, rd);
        chk("R1 mask", rd, RST_MASK);

        // R6/R7 with R1 mask: each line alone
        for (int i = 0; i < 32; i++)
            drive_check("R6/R7 single line", 32'd1 << i);

        // R2/R3/R6/R7 random patterns
        for (int k = 0; k < 40; k++) begin
            seed = next_rand(seed);
            model_mask = seed;
            bus_write(8'h48, seed);
            bus_read(8'h48, rd);
            chk("R2 readback", rd, model_mask);
            seed = next_rand(seed);
            drive_check("R6/R7 random", seed);
            bus_read(8'h44, rd);
            chk("R3 status", rd, seed & model_mask);
        end

        // R4: write to status offset ignored
        bus_write(8'h44, 32'hDEAD_BEEF);
        bus_read(8'h48, rd);
        chk("R4 mask kept", rd, model_mask);

        // R5: other offsets
        bus_write(8'h4C, 32'h0000_0000);
        bus_write(8'h49, 32'h0000_0000);
        bus_read(8'h48, rd);
        chk("R5 mask kept", rd, model_mask);
        bus_read(8'h40, rd); chk("R5 read 0x40", rd, 32'd0);
        bus_read(8'h4C, rd); chk("R5 read 0x4C", rd, 32'd0);
        bus_read(8'h45, rd); chk("R5 read 0x45", rd, 32'd0);
        bus_read(8'h00, rd); chk("R5 read 0x00", rd, 32'd0);

        // R8: no latching
        model_mask = 32'hFFFF_FFFF;
        bus_write(8'h48, model_mask);
        drive_check("R8 rise", 32'h0000_0008);
        drive_check("R8 fall", 32'h0000_0000);
        drive_check("R8 fast rise", FAST);
        drive_check("R8 fast fall", 32'h0000_0000);

        // R9: mask write latency, line 5 and line 8 held high
        drive_check("R9 setup", 32'h0000_0120);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h0;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R9 old irq", {31'b0, irq_out}, 32'd1);
        chk("R9 old fiq", {31'b0, fiq_out}, 32'd1);
        @(negedge clk);
        chk("R9 new irq", {31'b0, irq_out}, 32'd0);
        chk("R9 new fiq", {31'b0, fiq_out}, 32'd0);

        // R1: reset again restores mask
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset irq", {31'b0, irq_out}, 32'd0);
        rst = 1'b0;
        model_mask = RST_MASK;
        drive_check("R1 line 11 off", 32'h0000_0800);
        drive_check("R1 line 16 off", 32'h0001_0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule